// File: doc/BRIEF.md
# Circulating Serial Word Memory

This block models a main store made of recirculating lines. Every line holds a fixed number of words that pass a read/write point one after another, one word per word time. A word time is as many clocks as a word has bits, because the words move least significant bit first. Storage is held in an array. A single slot counter, shared by all lines, names the word now passing the access point, so an access has to wait until its word comes round.

A requester presents an address, a read/write flag and write data, and holds them until the response. The address is split into a line number in the upper bits and a word position in the lower bits. The access completes at the end of the slot whose number equals the word position. A one-cycle response then returns the word. The least significant bit of each stored word is a tag. A word with the tag set holds an instruction, and a write to it replaces only its address field. The default geometry is 64 lines of 32 words. Setting `LINE_BITS` to 8 gives 256 lines, 8192 words and a 13-bit address.

Top module: `circ_word_mem`

## Requirements
- R1: While `rstN` is low and on the first clock after its release, `rspValid` is 0. Reset sets the bit counter and the slot counter to 0.
- R2: Address bits [WORD_BITS-1:0] give the word position and the bits above them give the line number. Words that share a position but sit in different lines are stored independently.
- R3: One slot lasts WIDTH (32) clocks. The slot counter advances by one after the last clock of each slot and wraps from 31 to 0. After n clocks out of reset it equals (n/32) mod 32.
- R4: A request is accepted on the first clock edge at which the block is idle and `reqValid` is 1. The operation is carried out at the first later edge that ends a slot whose number equals the word position. `rspValid` rises on the following edge. The wait is therefore between 0 and 31 word times, plus the slot in progress.
- R5: `rspValid` is high for exactly one cycle per accepted request. A request still held during that cycle is not taken again.
- R6: A read response returns the stored 32-bit word unchanged.
- R7: A write to a word whose bit 0 is 0 replaces all 32 bits with the write data. This includes bit 0, so the word can become an instruction.
- R8: A write to a word whose bit 0 is 1 replaces only bits [31:19] with write data bits [31:19]. Bits [18:0], including the tag, keep their old values.
- R9: A write response returns the word as it is stored after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present; held until the response |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | LINE_BITS+WORD_BITS | Line number (upper bits) and word position (lower bits) |
| reqData | input | WIDTH | Write data |
| rspValid | output | 1 | One-cycle completion strobe |
| rspData | output | WIDTH | Word read, or word after the write |

## Verification
Requests are issued at many different phases of the circulation. Some are launched so that the target slot is the very next one to finish, which gives the shortest wait. Others target position 31 or lie behind the current slot, which forces a full wrap. Every response is timed against a cycle count derived only from R3 and R4, so an off-by-one in the slot or bit counting is caught. Write patterns pair data words and instruction words with write data whose low bits differ from the stored word, so a full replacement and a field-only replacement produce different read-backs. Addresses that share a word position across lines separate line decoding from word decoding.

// File: rtl/circmem_pkg.sv
package circmem_pkg;
  typedef struct packed {
    logic capture;  // latch the request fields
    logic commit;   // perform the access in the current slot
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } ctrlState_e;
endpackage

// File: rtl/circmem_slot_timer.sv
module circmem_slot_timer #(
  parameter int BITS_PER_SLOT = 32,
  parameter int SLOTS         = 32,
  parameter int SLOT_W        = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              bitLast,
  output logic [SLOT_W-1:0] slotNow
);
  localparam int BIT_W = $clog2(BITS_PER_SLOT);
  localparam logic [BIT_W-1:0]  BIT_MAX  = BIT_W'(BITS_PER_SLOT - 1);
  localparam logic [SLOT_W-1:0] SLOT_MAX = SLOT_W'(SLOTS - 1);

  logic [BIT_W-1:0] bitCnt;

  assign bitLast = (bitCnt == BIT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      slotNow <= '0;
    end else if (bitLast) begin
      bitCnt  <= '0;
      slotNow <= (slotNow == SLOT_MAX) ? '0 : slotNow + SLOT_W'(1);
    end else begin
      bitCnt  <= bitCnt + BIT_W'(1);
    end
  end

  // R3: the slot number moves only at a slot boundary, by exactly one, with wrap
  p_slot_advance_r3: assert property (@(posedge clk) disable iff (!rstN)
    bitLast |=> slotNow == (($past(slotNow) == SLOT_MAX) ? '0 : $past(slotNow) + SLOT_W'(1)));
  p_slot_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !bitLast |=> $stable(slotNow));
  p_slot_len_r3: assert property (@(posedge clk) disable iff (!rstN)
    bitLast |=> !bitLast);
endmodule

// File: rtl/circmem_datapath.sv
module circmem_datapath
  import circmem_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter int LINE_BITS  = 6,
  parameter int WORD_BITS  = 5,
  parameter int FIELD_BITS = 13,
  parameter int ADDR_W     = LINE_BITS + WORD_BITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic                 reqWrite,
  input  logic [WIDTH-1:0]     reqData,
  input  logic                 bitLast,
  input  logic [WORD_BITS-1:0] slotNow,
  output logic                 slotHit,
  output logic [WIDTH-1:0]     rspData
);
  localparam int DEPTH     = 2 ** ADDR_W;
  localparam int KEEP_BITS = WIDTH - FIELD_BITS;

  logic [WIDTH-1:0]  store [DEPTH];
  logic [ADDR_W-1:0] addrQ;
  logic              writeQ;
  logic [WIDTH-1:0]  dataQ;
  logic [WIDTH-1:0]  oldWord;
  logic [WIDTH-1:0]  newWord;
  logic              tagSet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      writeQ <= 1'b0;
      dataQ  <= '0;
    end else if (strobe.capture) begin
      addrQ  <= reqAddr;
      writeQ <= reqWrite;
      dataQ  <= reqData;
    end
  end

  assign oldWord = store[addrQ];
  assign tagSet  = oldWord[0];
  assign slotHit = bitLast && (slotNow == addrQ[WORD_BITS-1:0]);

  // instruction words take only their address field from the write data
  always_comb begin
    if (tagSet) newWord = {dataQ[WIDTH-1 -: FIELD_BITS], oldWord[KEEP_BITS-1:0]};
    else        newWord = dataQ;
  end

  always_ff @(posedge clk) begin
    if (strobe.commit && writeQ) store[addrQ] <= newWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rspData <= '0;
    else if (strobe.commit) rspData <= writeQ ? newWord : oldWord;
  end

  // R4: an access is committed only at the end of the addressed slot
  p_commit_in_slot_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |-> (bitLast && slotNow == addrQ[WORD_BITS-1:0]));
  // R8: a protected write keeps the low part and the tag of the old word
  p_protect_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && writeQ && tagSet) |=> rspData[KEEP_BITS-1:0] == $past(oldWord[KEEP_BITS-1:0]));
  // R7: a plain write responds with the full write data
  p_plain_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && writeQ && !tagSet) |=> rspData == $past(dataQ));
endmodule

// File: rtl/circmem_ctrl.sv
module circmem_ctrl
  import circmem_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        slotHit,
  output ctrlStrobe_t strobe,
  output logic        rspValid
);
  ctrlState_e state;
  ctrlState_e stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ST_IDLE: if (reqValid) begin
        strobe.capture = 1'b1;
        stateNext      = ST_WAIT;
      end
      ST_WAIT: if (slotHit) begin
        strobe.commit = 1'b1;
        stateNext     = ST_RESP;
      end
      ST_RESP: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign rspValid = (state == ST_RESP);

  // R5: one response pulse per access
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
  // R4: a response always follows a commit by one cycle
  p_resp_after_commit_r4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(strobe.commit));
  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.capture && strobe.commit));
endmodule

// File: rtl/circ_word_mem.sv
module circ_word_mem
  import circmem_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter int LINE_BITS  = 6,
  parameter int WORD_BITS  = 5,
  parameter int FIELD_BITS = 13,
  parameter int ADDR_W     = LINE_BITS + WORD_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WIDTH-1:0]  reqData,
  output logic              rspValid,
  output logic [WIDTH-1:0]  rspData
);
  localparam int SLOTS = 2 ** WORD_BITS;

  ctrlStrobe_t          strobe;
  logic                 bitLast;
  logic [WORD_BITS-1:0] slotNow;
  logic                 slotHit;

  circmem_slot_timer #(
    .BITS_PER_SLOT(WIDTH), .SLOTS(SLOTS), .SLOT_W(WORD_BITS)
  ) u_timer (
    .clk(clk), .rstN(rstN), .bitLast(bitLast), .slotNow(slotNow)
  );

  circmem_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .slotHit(slotHit),
    .strobe(strobe), .rspValid(rspValid)
  );

  circmem_datapath #(
    .WIDTH(WIDTH), .LINE_BITS(LINE_BITS), .WORD_BITS(WORD_BITS),
    .FIELD_BITS(FIELD_BITS), .ADDR_W(ADDR_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqData(reqData), .bitLast(bitLast),
    .slotNow(slotNow), .slotHit(slotHit), .rspData(rspData)
  );

  // R1: no response straight out of reset
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !rspValid);
endmodule

// File: tb/circ_word_mem_test.sv
module circ_word_mem_test;
  localparam int WIDTH = 32;
  localparam int LINE_BITS = 6;
  localparam int WORD_BITS = 5;
  localparam int ADDR_W = LINE_BITS + WORD_BITS;
  localparam int SLOT_LEN = 32;
  localparam int SLOTS = 32;

  typedef struct {
    int          cyc;
    logic [31:0] data;
    bit          chk;
    string       tag;
  } exp_t;

  logic clk = 0;
  logic rstN = 0;
  logic reqValid = 0;
  logic reqWrite = 0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [WIDTH-1:0] reqData = '0;
  logic rspValid;
  logic [WIDTH-1:0] rspData;

  int n = 0;
  int checks = 0;
  int errors = 0;
  bit prevValid = 0;
  logic [31:0] lastRsp;
  exp_t sb[$];
  logic [31:0] model [int];

  circ_word_mem uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqData(reqData), .rspValid(rspValid), .rspData(rspData)
  );

  always #5 clk = ~clk;

  always @(posedge clk) if (rstN) n <= n + 1;

  task automatic fail(input string tag, input string what, input int act, input int exp);
    errors++;
    $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
  endtask

  // monitor: pops the scoreboard on every response
  always @(negedge clk) begin
    exp_t e;
    if (rstN && rspValid) begin
      checks++;
      if (prevValid) fail("R5", "rspValid longer than one cycle", 1, 0);
      if (sb.size() == 0) begin
        checks++;
        fail("R5", "unexpected response", n, -1);
      end else begin
        e = sb.pop_front();
        checks++;
        if (n != e.cyc) fail("R3 R4", "response cycle", n, e.cyc);
        if (e.chk) begin
          checks++;
          if (rspData !== e.data) fail(e.tag, "response data", rspData, e.data);
        end
      end
    end
    prevValid = rspValid;
  end

  // driver: issues one access and pushes the expected response
  task automatic access(input bit wr, input int addr, input logic [31:0] data,
                        input bit chk, input string tag, input bit aligned);
    int w = addr % SLOTS;
    int m;
    exp_t e;
    logic [31:0] old;
    @(negedge clk);
    if (aligned)
      while (!(((n + 1) % SLOT_LEN) == SLOT_LEN - 1 && (((n + 1) / SLOT_LEN) % SLOTS) == w))
        @(negedge clk);
    m = n + 1;
    while (!((m % SLOT_LEN) == SLOT_LEN - 1 && ((m / SLOT_LEN) % SLOTS) == w)) m++;
    e.cyc = m + 1;
    e.chk = chk;
    e.tag = tag;
    if (wr) begin
      old = model[addr];
      if (old[0]) e.data = {data[31:19], old[18:0]};
      else        e.data = data;
      model[addr] = e.data;
    end else begin
      e.data = model.exists(addr) ? model[addr] : 32'h0;
    end
    sb.push_back(e);
    reqValid = 1; reqWrite = wr; reqAddr = ADDR_W'(addr); reqData = data;
    do @(negedge clk); while (!rspValid);
    lastRsp = rspData;
    reqValid = 0;
  endtask

  // fresh words get their initial contents from a read before any write
  task automatic prime(input int addr);
    if (!model.exists(addr)) begin
      access(0, addr, 32'h0, 0, "prime", 0);
      model[addr] = lastRsp;
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data, input string tag, input bit aligned = 0);
    prime(addr);
    access(1, addr, data, 1, tag, aligned);
  endtask

  task automatic rd(input int addr, input string tag, input bit aligned = 0);
    access(0, addr, 32'h0, 1, tag, aligned);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rspValid !== 1'b0) fail("R1", "rspValid in reset", rspValid, 0);
    rstN = 1;
    @(negedge clk);
    checks++;
    if (rspValid !== 1'b0) fail("R1", "rspValid after reset", rspValid, 0);

    // R7 plain data write (tag 0), R6 read-back, R9 write response
    wr(3, 32'h0000_0000, "R7");
    wr(3, 32'hA5A5_5A5A, "R9");
    rd(3, "R6");
    // R7 a plain write may set the tag; R8 then guards the word
    wr(40, 32'h0000_0000, "R7");
    wr(40, 32'h1234_5679, "R7");
    wr(40, 32'hFFF8_0000, "R8");
    rd(40, "R8");
    wr(40, 32'h0007_FFFE, "R8");
    rd(40, "R8");
    // R2 same word position, different lines
    wr(31, 32'h0, "R2");
    wr(31, 32'h1111_0000, "R2");
    wr(31 + 32, 32'h0, "R2");
    wr(31 + 32, 32'h2222_0000, "R2");
    wr(31 + 32 * 63, 32'h0, "R2");
    wr(31 + 32 * 63, 32'h3333_0000, "R2");
    rd(31, "R2");
    rd(31 + 32, "R2");
    rd(31 + 32 * 63, "R2");
    // R4 shortest wait: the target slot ends right after acceptance
    rd(3, "R4", 1);
    rd(31, "R4", 1);
    wr(40, 32'hABCD_E000, "R8", 1);
    rd(40, "R6");
    // R4 back-to-back requests to slot 0 after slot 31 (wrap), R3
    rd(31, "R3");
    rd(0 + 32 * 5, "R3");
    // mixed pattern over many lines and positions
    for (int i = 0; i < 12; i++) begin
      int a = (i * 389 + 7) % (1 << ADDR_W);
      logic [31:0] d = 32'h9E37_79B9 * (i + 1);
      wr(a, d, d[0] ? "R7" : "R7");
      wr(a, ~d, "R8");
      rd(a, "R6");
    end
    repeat (3) @(negedge clk);
    checks++;
    if (sb.size() != 0) fail("R5", "responses missing", sb.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule